// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block guards a small configuration register space behind a byte-wide I/O port pair. After reset the pair stays silent. It opens only when the host writes the enter key 83h twice in a row to the index port. While open, a write to the index port picks a register, and the data port at the next address reads or writes that register. Writing the exit key AAh to the index port closes the pair again.

The register space has two parts. Global registers sit below 30h and can always be reached. Indices from 30h upward reach a bank of per-device registers, and the device number held at index 07h selects which bank. A strap input is sampled during reset and sets the port pair to 2Eh/2Fh or 4Eh/4Fh. Software can move the pair later through a select bit. The global space also holds a lock bit, a software-reset trigger and two identification bytes.

Top module: `cfgk_top`

## Requirements
- R1: Two consecutive writes of 83h to the index port (at the base address) open configuration mode. After that, a read of the data port (base+1) returns the register selected by the last index write.
- R2: Between the two key writes, any other value written to the index port, or any read or write at either port, restarts key detection. Two more consecutive 83h writes are then needed.
- R3: Outside configuration mode, data-port reads return 00h. Data-port and index-port writes change no register and no index.
- R4: In configuration mode, writing AAh to the index port leaves the mode. Later data-port reads return 00h until the mode is opened again.
- R5: The port pair sits at 2Eh/2Fh when the address-select bit (bit 6 of index 26h) is 0, and at 4Eh/4Fh when it is 1. Its reset value is the inverse of the strap input sampled during reset. Accesses to the other pair have no effect.
- R6: Index 07h holds the device number, full 8 bits read/write, reset 00h. Indices 30h to 30h+BANK_REGS-1 reach a read/write byte bank that belongs to the selected device, reset 00h. Banks of different devices are independent. With a device number of NUM_DEV or more, bank reads return 00h and bank writes are ignored.
- R7: Index 20h reads 71h and index 21h reads 10h plus the 4-bit revision. Index 26h reads bit 6 = address select and bit 5 = lock, with all other bits 0. It therefore reads 40h after a reset with strap 0 and 00h after a reset with strap 1. Indices that are not implemented read 00h and ignore writes.
- R8: While the lock bit (bit 5 of index 26h) is 1, data-port writes to any index other than 26h are ignored and reads of those indices return FFh. Index 26h stays readable and writable.
- R9: Writing a value with bit 0 = 1 to index 02h (when not locked) restores every register and the index to its reset value, keeps the current address-select bit, and leaves configuration mode. Index 02h reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| strap_in | input | 1 | Address strap; 1 selects 2Eh/2Fh at reset, 0 selects 4Eh/4Fh |
| io_addr | input | 8 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid combinationally during a data-port read |

## Verification
A wrong key-sequencer state shows up on the first data-port read after the suspect access. A mode that opened too early returns a register value where 00h is expected, and a mode that failed to open returns 00h where a known ID byte is expected. A wrong address-select or lock bit shows up on the very next data-port read: the port answers at the wrong pair, or it returns FFh or real data where the other is expected. Bank or device-number corruption stays hidden until that bank is read back through the data port. For this reason the stimulus reads every written value back under several device numbers, and again after a software reset.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;

    localparam logic [7:0] KEY_ENTER  = 8'h83;
    localparam logic [7:0] KEY_EXIT   = 8'hAA;
    localparam logic [7:0] BASE_LOW   = 8'h2E;
    localparam logic [7:0] BASE_HIGH  = 8'h4E;

    localparam logic [7:0] IDX_SWRST  = 8'h02;
    localparam logic [7:0] IDX_DEVNUM = 8'h07;
    localparam logic [7:0] IDX_ID_HI  = 8'h20;
    localparam logic [7:0] IDX_ID_LO  = 8'h21;
    localparam logic [7:0] IDX_OPTION = 8'h26;
    localparam logic [7:0] IDX_BANK0  = 8'h30;

    localparam logic [7:0] ID_HI_VAL  = 8'h71;
    localparam logic [3:0] ID_LO_TOP  = 4'h1;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_t;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       at_idx;
        logic       at_dat;
        logic [7:0] data;
    } port_acc_t;

    function automatic logic [7:0] port_base(input logic sel);
        return sel ? BASE_HIGH : BASE_LOW;
    endfunction

endpackage

// File: rtl/cfgk_portdec.sv
module cfgk_portdec
    import cfgk_pkg::*;
(
    input  logic       addr_sel,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output port_acc_t  acc
);
    logic [7:0] base;

    always_comb begin
        base       = port_base(addr_sel);
        acc.wr     = io_wr;
        acc.rd     = io_rd;
        acc.at_idx = (io_addr == base);
        acc.at_dat = (io_addr == (base + 8'd1));
        acc.data   = io_wdata;
    end
endmodule

// File: rtl/cfgk_keyseq.sv
module cfgk_keyseq
    import cfgk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_rst,
    input  port_acc_t acc,
    output logic      in_mode
);
    key_state_t state_q;
    logic       idx_wr;
    logic       any_acc;

    assign idx_wr  = acc.wr && acc.at_idx;
    assign any_acc = (acc.wr || acc.rd) && (acc.at_idx || acc.at_dat);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state_q <= KS_IDLE;
        end else begin
            case (state_q)
                KS_IDLE: if (idx_wr && acc.data == KEY_ENTER) state_q <= KS_HALF;
                KS_HALF: begin
                    if (idx_wr && acc.data == KEY_ENTER) state_q <= KS_OPEN;
                    else if (any_acc)                    state_q <= KS_IDLE;
                end
                KS_OPEN: if (idx_wr && acc.data == KEY_EXIT) state_q <= KS_IDLE;
                default: state_q <= KS_IDLE;
            endcase
        end
    end

    assign in_mode = (state_q == KS_OPEN);
endmodule

// File: rtl/cfgk_regfile.sv
module cfgk_regfile
    import cfgk_pkg::*;
#(
    parameter int         NUM_DEV   = 4,
    parameter int         BANK_REGS = 4,
    parameter logic [3:0] REV       = 4'h3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_in,
    input  logic       in_mode,
    input  port_acc_t  acc,
    output logic [7:0] rdata,
    output logic       soft_rst,
    output logic       addr_sel,
    output logic       lock_o,
    output logic [7:0] dev_o,
    output logic [7:0] idx_o
);
    localparam int         CELLS  = NUM_DEV * BANK_REGS;
    localparam logic [7:0] BANK_N = 8'(BANK_REGS);
    localparam logic [7:0] DEV_N  = 8'(NUM_DEV);

    logic [7:0]         index_q;
    logic [7:0]         dev_q;
    logic               lock_q;
    logic               sel_q;
    logic [CELLS*8-1:0] bank_flat;

    logic       idx_wr;
    logic       dat_wr;
    logic       wr_ok;
    logic [7:0] off;
    logic       bank_hit;
    logic       dev_ok;
    logic       bank_we;
    logic [7:0] bank_rd;
    logic [7:0] rd_val;

    assign idx_wr   = in_mode && acc.wr && acc.at_idx && (acc.data != KEY_EXIT);
    assign dat_wr   = in_mode && acc.wr && acc.at_dat;
    assign wr_ok    = dat_wr && (!lock_q || index_q == IDX_OPTION);
    assign soft_rst = wr_ok && (index_q == IDX_SWRST) && acc.data[0];

    assign off      = index_q - IDX_BANK0;
    assign bank_hit = (index_q >= IDX_BANK0) && (off < BANK_N);
    assign dev_ok   = (dev_q < DEV_N);
    assign bank_we  = wr_ok && bank_hit && dev_ok;

    // Address select survives a software reset; only the hard reset loads the strap.
    always_ff @(posedge clk) begin
        if (rst)                                  sel_q <= ~strap_in;
        else if (wr_ok && index_q == IDX_OPTION)  sel_q <= acc.data[6];
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            index_q <= 8'h00;
            dev_q   <= 8'h00;
            lock_q  <= 1'b0;
        end else begin
            if (idx_wr) index_q <= acc.data;
            if (wr_ok && index_q == IDX_DEVNUM) dev_q  <= acc.data;
            if (wr_ok && index_q == IDX_OPTION) lock_q <= acc.data[5];
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar r = 0; r < BANK_REGS; r++) begin : g_reg
            logic [7:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    cell_q <= 8'h00;
                else if (bank_we && dev_q == 8'(d) && off == 8'(r))
                    cell_q <= acc.data;
            end
            assign bank_flat[(d*BANK_REGS + r)*8 +: 8] = cell_q;
        end
    end

    always_comb begin
        bank_rd = 8'h00;
        if (bank_hit && dev_ok)
            bank_rd = bank_flat[(int'(dev_q)*BANK_REGS + int'(off))*8 +: 8];
    end

    always_comb begin
        rd_val = 8'h00;
        if (bank_hit) begin
            rd_val = bank_rd;
        end else begin
            case (index_q)
                IDX_DEVNUM: rd_val = dev_q;
                IDX_ID_HI:  rd_val = ID_HI_VAL;
                IDX_ID_LO:  rd_val = {ID_LO_TOP, REV};
                IDX_OPTION: rd_val = {1'b0, sel_q, lock_q, 5'b0};
                default:    rd_val = 8'h00;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (in_mode && acc.rd && acc.at_dat)
            rdata = (lock_q && index_q != IDX_OPTION) ? 8'hFF : rd_val;
    end

    assign addr_sel = sel_q;
    assign lock_o   = lock_q;
    assign dev_o    = dev_q;
    assign idx_o    = index_q;
endmodule

// File: rtl/cfgk_top.sv
module cfgk_top
    import cfgk_pkg::*;
#(
    parameter int         NUM_DEV   = 4,
    parameter int         BANK_REGS = 4,
    parameter logic [3:0] REV       = 4'h3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_in,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata
);
    port_acc_t  acc;
    logic       addr_sel;
    logic       in_mode;
    logic       soft_rst;
    logic       lock_w;
    logic [7:0] dev_w;
    logic [7:0] idx_w;

    cfgk_portdec u_dec (
        .addr_sel (addr_sel),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .acc      (acc)
    );

    cfgk_keyseq u_key (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .acc      (acc),
        .in_mode  (in_mode)
    );

    cfgk_regfile #(
        .NUM_DEV   (NUM_DEV),
        .BANK_REGS (BANK_REGS),
        .REV       (REV)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .strap_in (strap_in),
        .in_mode  (in_mode),
        .acc      (acc),
        .rdata    (io_rdata),
        .soft_rst (soft_rst),
        .addr_sel (addr_sel),
        .lock_o   (lock_w),
        .dev_o    (dev_w),
        .idx_o    (idx_w)
    );
endmodule

// File: rtl/cfgk_chk.sv
module cfgk_chk
    import cfgk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input port_acc_t  acc,
    input logic       in_mode,
    input logic       lock_w,
    input logic [7:0] dev_w,
    input logic [7:0] idx_w,
    input logic [7:0] io_rdata
);
    AST_ENTRY_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(in_mode) |-> $past(acc.wr && acc.at_idx && acc.data == KEY_ENTER)); // R1

    AST_FROZEN_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !in_mode |=> ($stable(dev_w) && $stable(lock_w) && $stable(idx_w))); // R3

    AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !in_mode |-> (io_rdata == 8'h00)); // R3

    AST_EXIT_KEY: assert property (@(posedge clk) disable iff (rst)
        (in_mode && acc.wr && acc.at_idx && acc.data == KEY_EXIT) |=> !in_mode); // R4

    AST_LOCK_READS_FF: assert property (@(posedge clk) disable iff (rst)
        (in_mode && lock_w && acc.rd && acc.at_dat && idx_w != IDX_OPTION)
            |-> (io_rdata == 8'hFF)); // R8

    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (in_mode && !lock_w && acc.wr && acc.at_dat && idx_w == IDX_SWRST && acc.data[0])
            |=> (!in_mode && !lock_w && dev_w == 8'h00 && idx_w == 8'h00)); // R9
endmodule

bind cfgk_top cfgk_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .in_mode  (in_mode),
    .lock_w   (lock_w),
    .dev_w    (dev_w),
    .idx_w    (idx_w),
    .io_rdata (io_rdata)
);

// File: tb/cfgk_top_tb.sv
`timescale 1ns/1ps
module cfgk_top_tb;
    localparam logic [3:0] REV = 4'h3;
    localparam logic [7:0] ID_LO = {4'h1, REV};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_in = 1'b1;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cfgk_top #(.NUM_DEV(4), .BANK_REGS(4), .REV(REV)) u_dut (
        .clk(clk), .rst(rst), .strap_in(strap_in), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    // op[20]: 0 write, 1 read-and-compare; req[19:16]; addr[15:8]; data/expected[7:0]
    localparam int NV = 39;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {1'b1, 4'd3, 8'h2F, 8'h00},  // R3 closed port reads 00h
        {1'b0, 4'd1, 8'h2E, 8'h83},
        {1'b0, 4'd1, 8'h2E, 8'h83},  // R1 open
        {1'b0, 4'd7, 8'h2E, 8'h20},
        {1'b1, 4'd7, 8'h2F, 8'h71},  // R7 id high
        {1'b0, 4'd7, 8'h2E, 8'h21},
        {1'b1, 4'd7, 8'h2F, ID_LO},  // R7 id low
        {1'b0, 4'd5, 8'h2E, 8'h26},
        {1'b1, 4'd5, 8'h2F, 8'h00},  // R5 strap 1 gives select 0
        {1'b0, 4'd6, 8'h2E, 8'h07},
        {1'b0, 4'd6, 8'h2F, 8'h01},
        {1'b0, 4'd6, 8'h2E, 8'h30},
        {1'b0, 4'd6, 8'h2F, 8'hA5},
        {1'b0, 4'd6, 8'h2E, 8'h31},
        {1'b0, 4'd6, 8'h2F, 8'h5A},
        {1'b0, 4'd6, 8'h2E, 8'h07},
        {1'b0, 4'd6, 8'h2F, 8'h02},
        {1'b0, 4'd6, 8'h2E, 8'h30},
        {1'b1, 4'd6, 8'h2F, 8'h00},  // R6 other bank untouched
        {1'b0, 4'd6, 8'h2F, 8'h3C},
        {1'b1, 4'd6, 8'h2F, 8'h3C},
        {1'b0, 4'd6, 8'h2E, 8'h07},
        {1'b0, 4'd6, 8'h2F, 8'h01},
        {1'b0, 4'd6, 8'h2E, 8'h30},
        {1'b1, 4'd6, 8'h2F, 8'hA5},  // R6 bank 1 kept
        {1'b0, 4'd6, 8'h2E, 8'h31},
        {1'b1, 4'd6, 8'h2F, 8'h5A},
        {1'b0, 4'd6, 8'h2E, 8'h07},
        {1'b0, 4'd6, 8'h2F, 8'h09},
        {1'b0, 4'd6, 8'h2E, 8'h30},
        {1'b0, 4'd6, 8'h2F, 8'h77},
        {1'b1, 4'd6, 8'h2F, 8'h00},  // R6 out-of-range device
        {1'b0, 4'd6, 8'h2E, 8'h07},
        {1'b1, 4'd6, 8'h2F, 8'h09},
        {1'b0, 4'd7, 8'h2E, 8'h55},
        {1'b0, 4'd7, 8'h2F, 8'h66},
        {1'b1, 4'd7, 8'h2F, 8'h00},  // R7 unimplemented index
        {1'b0, 4'd4, 8'h2E, 8'hAA},
        {1'b1, 4'd4, 8'h2F, 8'h00}   // R4 closed after exit key
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        strap_in = s;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        do_reset(1'b1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                bus_rd(VEC[i][15:8], v);
                check($sformatf("R%0d vector %0d", VEC[i][19:16], i), v, VEC[i][7:0]);
            end else begin
                bus_wr(VEC[i][15:8], VEC[i][7:0]);
            end
        end

        // R5: strap 0 places the pair at 4Eh; keys at 2Eh do nothing
        do_reset(1'b0);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h4E, 8'h26);
        rd_chk("R5 keys at wrong pair", 8'h4F, 8'h00);
        bus_wr(8'h4E, 8'h83);
        bus_wr(8'h4E, 8'h83);
        bus_wr(8'h4E, 8'h26);
        rd_chk("R7 option after strap 0", 8'h4F, 8'h40);
        bus_wr(8'h4F, 8'h00);                 // R5 move pair to 2Eh
        bus_wr(8'h2E, 8'h20);
        rd_chk("R5 new pair answers", 8'h2F, 8'h71);
        rd_chk("R5 old pair silent", 8'h4F, 8'h00);

        // R2: broken key sequences
        bus_wr(8'h2E, 8'hAA);
        bus_wr(8'h2E, 8'h83);
        bus_rd(8'h2F, v);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h20);
        rd_chk("R2 read between keys", 8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h12);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h20);
        rd_chk("R2 other value between keys", 8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h20);
        rd_chk("R1 reopen", 8'h2F, 8'h71);

        // R8: lock behaviour
        bus_wr(8'h2E, 8'h07);
        bus_wr(8'h2F, 8'h01);
        bus_wr(8'h2E, 8'h26);
        bus_wr(8'h2F, 8'h20);
        rd_chk("R8 option readable when locked", 8'h2F, 8'h20);
        bus_wr(8'h2E, 8'h07);
        rd_chk("R8 locked read", 8'h2F, 8'hFF);
        bus_wr(8'h2F, 8'h03);
        bus_wr(8'h2E, 8'h02);
        bus_wr(8'h2F, 8'h01);                 // swrst blocked by lock
        bus_wr(8'h2E, 8'h26);
        bus_wr(8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h07);
        rd_chk("R8 locked writes ignored", 8'h2F, 8'h01);

        // R9: software reset
        bus_wr(8'h2E, 8'h30);
        bus_wr(8'h2F, 8'hC3);
        rd_chk("R6 bank write", 8'h2F, 8'hC3);
        bus_wr(8'h2E, 8'h02);
        rd_chk("R9 swrst index reads 00h", 8'h2F, 8'h00);
        bus_wr(8'h2F, 8'h01);
        rd_chk("R9 mode left", 8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h83);
        rd_chk("R9 index cleared", 8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h26);
        rd_chk("R9 select kept", 8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h07);
        rd_chk("R9 device cleared", 8'h2F, 8'h00);
        bus_wr(8'h2F, 8'h01);
        bus_wr(8'h2E, 8'h30);
        rd_chk("R9 bank cleared", 8'h2F, 8'h00);

        // R3: writes while closed change nothing
        bus_wr(8'h2E, 8'hAA);
        bus_wr(8'h2E, 8'h07);
        bus_wr(8'h2F, 8'h02);
        bus_wr(8'h2E, 8'h83);
        bus_wr(8'h2E, 8'h83);
        rd_chk("R3 index kept while closed", 8'h2F, 8'h00);
        bus_wr(8'h2E, 8'h07);
        rd_chk("R3 device kept while closed", 8'h2F, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule